// File: doc/BRIEF.md
# Nibble-Serial Sample Word Link Controller

This block sits on the digital side of a converter data link that carries 16-bit samples as 4-bit nibbles. In the transmit direction it takes whole words from a host through a valid/ready handshake and drives them onto a 4-bit bus, one nibble per nibble-clock period. In the receive direction it collects nibbles from a 4-bit bus and hands each finished word to the host.

The converter side owns the timing. It supplies the nibble clock and a word-alignment strobe, and both data directions share them. The controller runs on its own fast system clock. It brings the selected nibble clock, the strobe and the receive nibbles through one common synchroniser, then acts on the detected edges. Outgoing nibbles change after a rising nibble-clock edge. Incoming nibbles and the strobe are taken on the falling edge.

One select input chooses which of two nibble-clock pins is used. The master clock is used in normal operation, and a separate nibble clock is used in the oversampled mode. Three one-cycle event outputs report receive overflow, transmit underflow and misplaced strobes.

Top module: `nibble_link_ctrl`

## Requirements
- R1: A received word is built from four nibbles, and the first nibble captured after the strobe becomes bits 3:0. Each later nibble fills the next higher 4 bits, so the fourth fills bits 15:12.
- R2: Each accepted transmit word is sent in acceptance order. Bits 3:0 go out first and bits 15:12 go out last.
- R3: `tx_nib` changes only in response to a rising edge of the selected nibble clock. It holds its value in the system-clock cycles that come straight after that edge at the pin.
- R4: Receive nibbles and the strobe are taken only on falling edges of the selected nibble clock. A completed word makes `rx_valid` rise in the cycle after that falling edge is detected.
- R5: With `nib_clk_sel`=0 the design uses `master_clk` and ignores `alt_nib_clk`. With `nib_clk_sel`=1 it uses `alt_nib_clk` and ignores `master_clk`.
- R6: A strobe sampled high marks the nibble captured on that edge as nibble 0 of a new word. The nibble counter realigns to it.
- R7: `rx_valid` stays high, with `rx_word` unchanged, until a cycle with `rx_ready` high accepts the word. It drops in the next cycle unless a new word completes.
- R8: If a word completes while the previous word is still unaccepted, the new word replaces it and `rx_overflow` pulses for one cycle.
- R9: If no word is buffered when nibble 0 is due, four zero nibbles are sent and `tx_underflow` pulses for one cycle.
- R10: A strobe that arrives when the previous nibble was not nibble 3 pulses `frame_err` for one cycle. A strobe after nibble 3 does not.
- R11: After reset, `tx_nib`=0, `rx_valid`=0, `tx_ready`=1, and all three event outputs are 0.
- R12: One transmit word can be buffered. `tx_ready` is high only while the buffer is empty and falls in the cycle after a word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_clk_sel | input | 1 | 0: nibble clock taken from master_clk; 1: from alt_nib_clk |
| master_clk | input | 1 | Converter master clock, used as the nibble clock in normal mode |
| alt_nib_clk | input | 1 | Separate nibble clock used in the oversampled mode |
| word_sync | input | 1 | Word-alignment strobe, high during nibble 0 |
| rx_nib | input | 4 | Receive nibble bus from the converter |
| tx_nib | output | 4 | Transmit nibble bus to the converter |
| rx_word | output | 16 | Assembled receive word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Host accepts the receive word |
| tx_word | input | 16 | Transmit word from the host |
| tx_valid | input | 1 | Host offers tx_word |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_overflow | output | 1 | One-cycle pulse: an unaccepted word was overwritten |
| tx_underflow | output | 1 | One-cycle pulse: a zero word was sent for lack of data |
| frame_err | output | 1 | One-cycle pulse: strobe arrived out of place |

## Verification
On every cycle, the assertions check the following. Transmit nibbles move only after a detected rising edge. A new receive word, the frame-error pulse and the underflow pulse each follow the matching edge event. An overflow pulse needs an unaccepted word to be present. The handshake registers behave as stated. The following can only be shown by the bench's scenarios, because each needs a whole word stream with known contents:
- the nibble order inside words in both directions;
- how the receive side recovers after a misplaced strobe;
- that the unselected clock pin really is ignored in each mode;
- that underflow sends zero words.

// File: rtl/nibble_link_pkg.sv
// Package: shared default sizes for the nibble-serial link controller.
// Assumes one word is an exact multiple of the nibble width.
package nibble_link_pkg;
    localparam int NIB_W_DEF      = 4;
    localparam int NIBS_DEF       = 4;
    localparam int SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/nlc_edge_sync.sv
// nlc_edge_sync: picks the nibble clock named by sel, then passes it through one
// shared synchroniser stack together with the strobe and receive nibble, and
// flags rising and falling edges of the synchronised clock.
// Assumes strobe and nibble are stable around the falling nibble-clock edge,
// so carrying them through the same stages keeps them aligned with that edge.
module nlc_edge_sync #(
    parameter int NIB_W      = nibble_link_pkg::NIB_W_DEF,
    parameter int SYNC_DEPTH = nibble_link_pkg::SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             sync_in,
    input  logic [NIB_W-1:0] nib_in,
    output logic             rise,
    output logic             fall,
    output logic             sync_s,
    output logic [NIB_W-1:0] nib_s
);
    localparam int BUS_W = NIB_W + 2;

    logic [BUS_W-1:0] pipe [SYNC_DEPTH];
    logic [BUS_W-1:0] bus_in;
    logic             clk_prev;
    logic             clk_s;

    assign bus_in = {(sel ? clk_b : clk_a), sync_in, nib_in};

    // Shift the sampled bus through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_DEPTH; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= bus_in;
            for (int k = 1; k < SYNC_DEPTH; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign clk_s  = pipe[SYNC_DEPTH-1][BUS_W-1];
    assign sync_s = pipe[SYNC_DEPTH-1][NIB_W];
    assign nib_s  = pipe[SYNC_DEPTH-1][NIB_W-1:0];

    // Keep last synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_s;
    end

    assign rise = clk_s & ~clk_prev;
    assign fall = ~clk_s & clk_prev;
endmodule

// File: rtl/nlc_frame_track.sv
// nlc_frame_track: nibble position counter shared by both directions.
// cnt holds the index of the nibble taken on the last falling edge; cap_idx is
// the index that the current falling edge will take. A strobe forces index 0
// and reports a framing error unless the previous nibble was the last one.
module nlc_frame_track #(
    parameter int NIBS  = nibble_link_pkg::NIBS_DEF,
    parameter int IDX_W = $clog2(NIBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             sync_s,
    output logic [IDX_W-1:0] cnt,
    output logic [IDX_W-1:0] cap_idx,
    output logic             frame_err
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

    // Index for the nibble taken on this falling edge.
    always_comb begin
        if (sync_s || cnt == LAST) cap_idx = '0;
        else                       cap_idx = cnt + 1'b1;
    end

    // Advance the position and flag strobes that land out of place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= LAST;
            frame_err <= 1'b0;
        end else if (fall) begin
            cnt       <= cap_idx;
            frame_err <= sync_s && (cnt != LAST);
        end else begin
            frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/nlc_rx_assemble.sv
// nlc_rx_assemble: stores each received nibble in its slot and, on the last
// slot, moves the whole word to the host register with a valid flag.
// Assumes cap_idx is only meaningful while fall is high.
module nlc_rx_assemble #(
    parameter int NIB_W = nibble_link_pkg::NIB_W_DEF,
    parameter int NIBS  = nibble_link_pkg::NIBS_DEF,
    parameter int IDX_W = $clog2(NIBS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fall,
    input  logic [IDX_W-1:0]      cap_idx,
    input  logic [NIB_W-1:0]      nib_s,
    input  logic                  rx_ready,
    output logic [NIB_W*NIBS-1:0] rx_word,
    output logic                  rx_valid,
    output logic                  rx_overflow
);
    localparam int WORD_W = NIB_W * NIBS;

    logic [WORD_W-1:0] assembled;
    logic              done;

    for (genvar i = 0; i < NIBS; i++) begin : g_slot
        logic [NIB_W-1:0] held;
        // Capture this slot's nibble when its index comes up.
        always_ff @(posedge clk) begin
            if (!rst_n)                               held <= '0;
            else if (fall && cap_idx == IDX_W'(i))    held <= nib_s;
        end
        assign assembled[i*NIB_W +: NIB_W] = (cap_idx == IDX_W'(i)) ? nib_s : held;
    end

    assign done = fall && (cap_idx == IDX_W'(NIBS - 1));

    // Present completed words and track host acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word     <= '0;
            rx_valid    <= 1'b0;
            rx_overflow <= 1'b0;
        end else if (done) begin
            rx_word     <= assembled;
            rx_valid    <= 1'b1;
            rx_overflow <= rx_valid && !rx_ready;
        end else begin
            rx_overflow <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nlc_tx_serialize.sv
// nlc_tx_serialize: one-word host buffer plus a shift word. On each rising
// edge it launches the nibble that follows the one last taken; at nibble 0 it
// loads the buffered word, or zeros with an underflow pulse when empty.
module nlc_tx_serialize #(
    parameter int NIB_W = nibble_link_pkg::NIB_W_DEF,
    parameter int NIBS  = nibble_link_pkg::NIBS_DEF,
    parameter int IDX_W = $clog2(NIBS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise,
    input  logic [IDX_W-1:0]      cnt,
    input  logic [NIB_W*NIBS-1:0] tx_word,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    output logic [NIB_W-1:0]      tx_nib,
    output logic                  tx_underflow
);
    localparam int               WORD_W = NIB_W * NIBS;
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(NIBS - 1);

    logic [WORD_W-1:0] hold;
    logic              full;
    logic [WORD_W-1:0] cur;
    logic [IDX_W-1:0]  launch_idx;
    logic              word_start;

    assign launch_idx = (cnt == LAST) ? '0 : cnt + 1'b1;
    assign word_start = rise && (launch_idx == '0);
    assign tx_ready   = !full;

    // Host-side buffer: fill when empty, drain at each word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (word_start && full) begin
            full <= 1'b0;
        end else if (tx_valid && !full) begin
            hold <= tx_word;
            full <= 1'b1;
        end
    end

    // Launch the next nibble on each rising nibble-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur          <= '0;
            tx_nib       <= '0;
            tx_underflow <= 1'b0;
        end else if (word_start) begin
            cur          <= full ? hold : '0;
            tx_nib       <= full ? hold[NIB_W-1:0] : '0;
            tx_underflow <= !full;
        end else begin
            tx_underflow <= 1'b0;
            if (rise) tx_nib <= cur[launch_idx*NIB_W +: NIB_W];
        end
    end
endmodule

// File: rtl/nibble_link_ctrl.sv
// nibble_link_ctrl: top of the nibble-serial sample word link. Connects the
// edge synchroniser, the shared frame tracker and the two data paths.
// Assumes the system clock runs at least eight times the nibble clock rate.
module nibble_link_ctrl #(
    parameter int NIB_W      = nibble_link_pkg::NIB_W_DEF,
    parameter int NIBS       = nibble_link_pkg::NIBS_DEF,
    parameter int SYNC_DEPTH = nibble_link_pkg::SYNC_DEPTH_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nib_clk_sel,
    input  logic                  master_clk,
    input  logic                  alt_nib_clk,
    input  logic                  word_sync,
    input  logic [NIB_W-1:0]      rx_nib,
    output logic [NIB_W-1:0]      tx_nib,
    output logic [NIB_W*NIBS-1:0] rx_word,
    output logic                  rx_valid,
    input  logic                  rx_ready,
    input  logic [NIB_W*NIBS-1:0] tx_word,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    output logic                  rx_overflow,
    output logic                  tx_underflow,
    output logic                  frame_err
);
    localparam int IDX_W = $clog2(NIBS);

    logic             rise_evt;
    logic             fall_evt;
    logic             sync_s;
    logic [NIB_W-1:0] nib_s;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] cap_idx;

    nlc_edge_sync #(.NIB_W(NIB_W), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .sel(nib_clk_sel),
        .clk_a(master_clk), .clk_b(alt_nib_clk),
        .sync_in(word_sync), .nib_in(rx_nib),
        .rise(rise_evt), .fall(fall_evt), .sync_s(sync_s), .nib_s(nib_s)
    );

    nlc_frame_track #(.NIBS(NIBS), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .fall(fall_evt), .sync_s(sync_s),
        .cnt(cnt), .cap_idx(cap_idx), .frame_err(frame_err)
    );

    nlc_rx_assemble #(.NIB_W(NIB_W), .NIBS(NIBS), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fall(fall_evt), .cap_idx(cap_idx),
        .nib_s(nib_s), .rx_ready(rx_ready),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_overflow(rx_overflow)
    );

    nlc_tx_serialize #(.NIB_W(NIB_W), .NIBS(NIBS), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise_evt), .cnt(cnt),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_nib(tx_nib), .tx_underflow(tx_underflow)
    );
endmodule

// File: rtl/nibble_link_checker.sv
// nibble_link_checker: temporal properties of nibble_link_ctrl, bound in below.
module nibble_link_checker #(
    parameter int NIB_W  = 4,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rise_evt,
    input logic              fall_evt,
    input logic              sync_s,
    input logic [NIB_W-1:0]  tx_nib,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_overflow,
    input logic              tx_underflow,
    input logic              frame_err
);
    a_r3_tx_moves_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_nib) |-> $past(rise_evt));

    a_r4_word_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(fall_evt));

    a_r7_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !fall_evt) |=> (rx_valid && $stable(rx_word)));

    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> $past(rx_valid && !rx_ready && fall_evt));

    a_r9_underflow_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> $past(rise_evt));

    a_r10_frame_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(fall_evt && sync_s));

    a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind nibble_link_ctrl nibble_link_checker #(.NIB_W(NIB_W), .WORD_W(NIB_W*NIBS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .sync_s(sync_s), .tx_nib(tx_nib), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_overflow(rx_overflow), .tx_underflow(tx_underflow), .frame_err(frame_err)
);

// File: tb/nibble_link_ctrl_test.sv
module nibble_link_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nib_clk_sel = 1'b0;
    logic        nib_drv = 1'b0;
    logic        jam_q = 1'b0;
    logic        master_clk;
    logic        alt_nib_clk;
    logic        word_sync = 1'b0;
    logic [3:0]  rx_nib = 4'h0;
    logic [3:0]  tx_nib;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [15:0] tx_word = 16'h0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        rx_overflow, tx_underflow, frame_err;

    int total = 0;
    int fails = 0;

    // Selected pin carries the bench nibble clock, the other one a jamming toggle.
    assign master_clk  = nib_clk_sel ? jam_q : nib_drv;
    assign alt_nib_clk = nib_clk_sel ? nib_drv : jam_q;

    always #2 clk = ~clk;

    nibble_link_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nib_clk_sel(nib_clk_sel),
        .master_clk(master_clk), .alt_nib_clk(alt_nib_clk),
        .word_sync(word_sync), .rx_nib(rx_nib), .tx_nib(tx_nib),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_overflow(rx_overflow), .tx_underflow(tx_underflow), .frame_err(frame_err)
    );

    function automatic logic [15:0] rx_pat(input int k);
        if (k == 1) return 16'hFFFF;
        if (k == 2) return 16'h0000;
        return 16'(k * 40503) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] tx_pat(input int k);
        return 16'(k * 9029 + 16'h1234) ^ {4'(k), 12'h000};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Jammer on the unselected clock pin.
    int jam_cnt = 0;
    always @(negedge clk) begin
        jam_cnt++;
        if (jam_cnt % 3 == 0) jam_q = ~jam_q;
    end

    // Host transmit feeder.
    bit feed_en = 0;
    int feed_idx = 0;
    bit took = 0;
    always @(negedge clk) begin
        if (took) begin
            feed_idx++;
            took = 0;
        end
        tx_valid = feed_en && rst_n;
        tx_word  = tx_pat(feed_idx);
        if (tx_valid && tx_ready) took = 1;
    end

    // Monitors: accepted receive words and event pulses.
    logic [15:0] got [64];
    int got_n = 0, ovf_n = 0, unf_n = 0, fer_n = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_ready) begin
                if (got_n < 64) got[got_n] = rx_word;
                got_n++;
            end
            if (rx_overflow)  ovf_n++;
            if (tx_underflow) unf_n++;
            if (frame_err)    fer_n++;
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Bench view of transmit side.
    logic [15:0] tx_asm;
    logic [15:0] tx_got [64];
    int          tx_n = 0;
    logic [3:0]  prev_tx = 4'h0;

    // One nibble period: rise for 4 cycles, fall for 4 cycles.
    task automatic nib(input logic [3:0] v, input bit stb, input int slot);
        nib_drv = 1'b1; rx_nib = v; word_sync = stb;
        @(negedge clk);
        chk(tx_nib == prev_tx, "R3 tx_nib held just after rise", tx_nib, prev_tx);
        repeat (3) @(negedge clk);
        prev_tx = tx_nib;
        if (slot >= 0) begin
            tx_asm[slot*4 +: 4] = tx_nib;
            if (slot == 3) begin
                if (tx_n < 64) tx_got[tx_n] = tx_asm;
                tx_n++;
            end
        end
        nib_drv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w);
        for (int s = 0; s < 4; s++) nib(w[s*4 +: 4], s == 0, s);
    endtask

    task automatic do_reset(input bit sel, input bit feed);
        rst_n = 1'b0; feed_en = feed; nib_clk_sel = sel; nib_drv = 1'b0;
        word_sync = 1'b0; rx_nib = 4'h0; rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        feed_idx = 0; took = 0; got_n = 0; tx_n = 0; prev_tx = 4'h0;
        ovf_n = 0; unf_n = 0; fer_n = 0;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic sweep(input bit sel);
        localparam int N = 40;
        do_reset(sel, 1'b1);
        for (int k = 0; k < N; k++) frame(rx_pat(k));
        repeat (4) @(negedge clk);
        chk(got_n == N, "R5 word count in selected clock mode", got_n, N);
        chk(tx_n == N, "R5 tx word count", tx_n, N);
        for (int k = 0; k < N; k++) begin
            chk(got[k] == rx_pat(k), "R1 rx word nibble order", got[k], rx_pat(k));
            chk(tx_got[k] == tx_pat(k), "R2 tx word nibble order", tx_got[k], tx_pat(k));
        end
        chk(ovf_n == 0, "R8 no overflow with ready host", ovf_n, 0);
        chk(unf_n == 0, "R9 no underflow with fed host", unf_n, 0);
        chk(fer_n == 0, "R10 no frame error on aligned strobes", fer_n, 0);
    endtask

    initial begin
        // R11 reset state.
        do_reset(1'b0, 1'b0);
        chk(tx_nib == 4'h0, "R11 tx_nib after reset", tx_nib, 0);
        chk(rx_valid == 1'b0, "R11 rx_valid after reset", rx_valid, 0);
        chk(tx_ready == 1'b1, "R11 tx_ready after reset", tx_ready, 1);
        chk({rx_overflow, tx_underflow, frame_err} == 3'b000, "R11 events after reset",
            {rx_overflow, tx_underflow, frame_err}, 0);

        // R12: one word buffered, ready falls after it is taken.
        feed_en = 1;
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b0, "R12 tx_ready low with buffered word", tx_ready, 0);

        // R1 R2 R4 R5 in both clock modes.
        sweep(1'b0);
        sweep(1'b1);

        // R9 underflow: no host data, zero words and one pulse per word.
        do_reset(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) frame(rx_pat(k + 5));
        repeat (4) @(negedge clk);
        chk(unf_n == 3, "R9 underflow pulses", unf_n, 3);
        chk(tx_n == 3, "R9 tx frames seen", tx_n, 3);
        for (int k = 0; k < 3; k++)
            chk(tx_got[k] == 16'h0000, "R9 zero word sent", tx_got[k], 0);

        // R7 R8 overflow: host stalls across two words.
        do_reset(1'b0, 1'b0);
        rx_ready = 1'b0;
        frame(16'h1357);
        repeat (2) @(negedge clk);
        chk(rx_valid == 1'b1, "R7 rx_valid held while stalled", rx_valid, 1);
        chk(rx_word == 16'h1357, "R7 rx_word held while stalled", rx_word, 16'h1357);
        frame(16'hBEEF);
        repeat (2) @(negedge clk);
        chk(ovf_n == 1, "R8 overflow pulse count", ovf_n, 1);
        chk(rx_word == 16'hBEEF, "R8 newer word replaces", rx_word, 16'hBEEF);
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(got_n == 1, "R8 only one word delivered", got_n, 1);
        chk(got[0] == 16'hBEEF, "R8 delivered word", got[0], 16'hBEEF);
        chk(rx_valid == 1'b0, "R7 rx_valid drops after accept", rx_valid, 0);

        // R6 R10: misplaced strobe realigns the counter.
        do_reset(1'b1, 1'b0);
        frame(16'h4C2A);
        nib(4'h9, 1'b1, -1);
        nib(4'h8, 1'b0, -1);
        frame(16'h7E15);
        frame(16'h0F3D);
        repeat (4) @(negedge clk);
        chk(fer_n == 1, "R10 frame error count", fer_n, 1);
        chk(got_n == 3, "R6 words after realign", got_n, 3);
        chk(got[0] == 16'h4C2A, "R6 word before strobe slip", got[0], 16'h4C2A);
        chk(got[1] == 16'h7E15, "R6 word after realign", got[1], 16'h7E15);
        chk(got[2] == 16'h0F3D, "R6 next word after realign", got[2], 16'h0F3D);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule